// File: doc/BRIEF.md
# Hot-Swap Insertion/Extraction Signalling Controller

This block sits on a hot-swappable add-in board and handles the software side of connection control. It watches a debounced injector-handle switch, a "backend fully powered" flag from the power sequencer and the host's active-low board-select level. From these it raises a latched request on the shared, open-collector enumeration line. The host uses that request to learn that the board has just been seated or is about to be pulled. The same logic drives the blue extraction-permitted LED.

A board "session" exists while backend power is good and the host holds board-select low. Outside a session the LED is lit by hardware, so the operator can see that removal is safe. Once a session starts the LED goes dark and software takes it over. Moving the handle during a session latches an insertion or extraction pending bit. The enumeration pull-down stays active until software clears every pending bit through a small write port. A control register holds the software LED bit and a mask that hides the request without losing the pending state.

Top module: `hsw_enum_ctrl`

## Requirements
- R1: After reset, enum_pull is 0, led_on is 1, pend_bits is 0 and ctrl_bits is 0.
- R2: A session is present when power_good is 1 and host_sel_n is 0, both sampled on the same clock edge. On the edge after any cycle without a session, led_on becomes 1 (hardware-owned phase).
- R3: On the edge after a cycle with a session, led_on equals the software LED bit (ctrl_bits[0]), which is 0 when the session starts.
- R4: If handle_closed goes from 0 to 1 while a session is present, pend_bits[0] (insertion pending) is set on that edge.
- R5: If handle_closed goes from 1 to 0 while a session is present, pend_bits[1] (extraction pending) is set on that edge.
- R6: Handle edges that happen outside a session set no pending bit. A handle that is already closed when the session begins also sets no pending bit.
- R7: A write with wr_addr = 0 clears each pending bit whose wr_data bit is 1 (bit 0 is insertion, bit 1 is extraction). A 0 in wr_data leaves that bit as it was. If a handle event arrives in the same cycle as a clearing write, the event wins and the bit stays set.
- R8: enum_pull is 1 exactly when at least one pending bit is set and the mask bit (ctrl_bits[1]) is 0. Setting the mask releases the line but keeps the pending bits. Clearing the mask drives the line again.
- R9: A cycle without a session clears all pending and control bits on the next edge. This releases enum_pull and lights led_on.
- R10: Writes to either register in a cycle without a session have no effect.
- R11: A write with wr_addr = 1 loads wr_data[0] into the LED bit and wr_data[1] into the mask bit. The pending bits are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_good | input | 1 | Backend supplies fully up, from the power sequencer |
| host_sel_n | input | 1 | Host board-select level, active low |
| handle_closed | input | 1 | Debounced injector-handle switch, 1 = closed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = pending/status register, 1 = control register |
| wr_data | input | 2 | Write data |
| enum_pull | output | 1 | 1 = pull the shared enumeration line low, 0 = release |
| led_on | output | 1 | Blue LED drive, 1 = lit |
| pend_bits | output | 2 | Pending bits: [0] insertion, [1] extraction |
| ctrl_bits | output | 2 | Control bits: [0] software LED, [1] mask |

## Verification
The bench targets the cases where the priority between handle events and software clears matters. When a clearing write and a new handle edge land in the same cycle, a design that lets the write win would silently drop an extraction notice. Masking is checked for pending bits that survive it: a design that clears status on mask would lose the request when the mask is lifted. A handle already closed at session start is also checked, since a design that tracks the level instead of the edge would report a false insertion. Session loss and writes outside a session show whether stale software state leaks into the next session or keeps the LED dark on an unpowered board.

// File: rtl/hsw_pkg.sv
// Shared field positions and register types for the hot-swap signalling block.
package hsw_pkg;
    localparam int REG_W         = 2;
    localparam int ADDR_W        = 1;
    localparam int INS_BIT       = 0;
    localparam int EXT_BIT       = 1;
    localparam int LED_BIT       = 0;
    localparam int MASK_BIT      = 1;

    typedef struct packed {
        logic ext;
        logic ins;
    } pend_t;

    typedef struct packed {
        logic mask;
        logic led;
    } ctrl_t;
endpackage

// File: rtl/hsw_session.sv
// Session tracker: decides whether the board is powered and selected, and
// finds edges on the injector handle. Assumes handle_closed is already
// debounced and synchronous to clk.
module hsw_session (
    input  logic clk,
    input  logic rst_n,
    input  logic power_good,
    input  logic host_sel_n,
    input  logic handle_closed,
    output logic sess_now,
    output logic sess_q,
    output logic handle_rise,
    output logic handle_fall
);
    logic handle_prev;

    // Live session condition from the current input levels.
    always_comb sess_now = power_good & ~host_sel_n;

    // Register the session flag and the last handle level; during reset the
    // handle level is captured so no false edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_q      <= 1'b0;
            handle_prev <= handle_closed;
        end else begin
            sess_q      <= sess_now;
            handle_prev <= handle_closed;
        end
    end

    // Edge pulses against the previous sample.
    always_comb begin
        handle_rise = handle_closed & ~handle_prev;
        handle_fall = ~handle_closed & handle_prev;
    end

    assert_no_session_hw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sess_now |=> !sess_q);
endmodule

// File: rtl/hsw_regs.sv
// Pending (write-one-to-clear) and control registers. Assumes the session
// flag and handle edges come from hsw_session in the same cycle.
module hsw_regs
    import hsw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 1'b0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_now,
    input  logic              handle_rise,
    input  logic              handle_fall,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output pend_t             pend_q,
    output ctrl_t             ctrl_q
);
    pend_t pend_d;
    ctrl_t ctrl_d;
    logic  stat_wr, ctrl_wr;

    // Decode writes; only honoured inside a session.
    always_comb begin
        stat_wr = wr_en & sess_now & (wr_addr == STAT_ADDR);
        ctrl_wr = wr_en & sess_now & (wr_addr == CTRL_ADDR);
    end

    // Next pending state: clear first, then events override the clear.
    always_comb begin
        pend_d = pend_q;
        if (stat_wr) begin
            if (wr_data[INS_BIT]) pend_d.ins = 1'b0;
            if (wr_data[EXT_BIT]) pend_d.ext = 1'b0;
        end
        if (sess_now && handle_rise) pend_d.ins = 1'b1;
        if (sess_now && handle_fall) pend_d.ext = 1'b1;
        if (!sess_now) pend_d = '0;
    end

    // Next control state: loaded by writes, wiped when the session drops.
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.led  = wr_data[LED_BIT];
            ctrl_d.mask = wr_data[MASK_BIT];
        end
        if (!sess_now) ctrl_d = '0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ctrl_q <= '0;
        end else begin
            pend_q <= pend_d;
            ctrl_q <= ctrl_d;
        end
    end

    assert_ins_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_now && handle_rise) |=> pend_q.ins);
    assert_ext_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_now && handle_fall) |=> pend_q.ext);
    assert_hold_until_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q.ins && sess_now && !(wr_en && wr_addr == STAT_ADDR && wr_data[INS_BIT]))
        |=> pend_q.ins);
    assert_loss_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sess_now |=> (pend_q == '0 && ctrl_q == '0));
    assert_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sess_now && wr_en) |=> (ctrl_q == '0));
endmodule

// File: rtl/hsw_outputs.sv
// Output stage: enumeration pull-down enable and LED ownership. Assumes
// registered inputs, so both outputs are glitch-free.
module hsw_outputs
    import hsw_pkg::*;
(
    input  logic  sess_q,
    input  pend_t pend_q,
    input  ctrl_t ctrl_q,
    output logic  enum_pull,
    output logic  led_on
);
    // Pull the line while any event is pending and not masked.
    always_comb enum_pull = (pend_q.ins | pend_q.ext) & ~ctrl_q.mask;

    // Hardware owns the LED outside a session, software inside.
    always_comb led_on = sess_q ? ctrl_q.led : 1'b1;
endmodule

// File: rtl/hsw_enum_ctrl.sv
// Top: hot-swap insertion/extraction signalling with blue LED control.
// Assumes all inputs are synchronous to clk.
module hsw_enum_ctrl
    import hsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_good,
    input  logic              host_sel_n,
    input  logic              handle_closed,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              enum_pull,
    output logic              led_on,
    output logic [1:0]        pend_bits,
    output logic [1:0]        ctrl_bits
);
    logic  sess_now, sess_q, handle_rise, handle_fall;
    pend_t pend_q;
    ctrl_t ctrl_q;

    hsw_session u_session (
        .clk(clk), .rst_n(rst_n), .power_good(power_good),
        .host_sel_n(host_sel_n), .handle_closed(handle_closed),
        .sess_now(sess_now), .sess_q(sess_q),
        .handle_rise(handle_rise), .handle_fall(handle_fall)
    );

    hsw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sess_now(sess_now),
        .handle_rise(handle_rise), .handle_fall(handle_fall),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pend_q(pend_q), .ctrl_q(ctrl_q)
    );

    hsw_outputs u_out (
        .sess_q(sess_q), .pend_q(pend_q), .ctrl_q(ctrl_q),
        .enum_pull(enum_pull), .led_on(led_on)
    );

    // Expose register state at the ports.
    always_comb begin
        pend_bits = pend_q;
        ctrl_bits = ctrl_q;
    end

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[1] |-> !enum_pull);
    assert_idle_led_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sess_q |-> led_on);
    assert_pull_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enum_pull |-> (pend_bits != 2'b00));
endmodule

// File: tb/hsw_enum_ctrl_tb.sv
`timescale 1ns/1ps
module hsw_enum_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_good = 1'b0, host_sel_n = 1'b1, handle_closed = 1'b0;
    logic wr_en = 1'b0;
    logic [0:0] wr_addr = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic enum_pull, led_on;
    logic [1:0] pend_bits, ctrl_bits;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic m_ins = 0, m_ext = 0, m_led = 0, m_mask = 0, m_hprev = 0, m_sess = 0;

    always #2.5 clk = ~clk;

    hsw_enum_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .power_good(power_good), .host_sel_n(host_sel_n),
        .handle_closed(handle_closed), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .enum_pull(enum_pull), .led_on(led_on),
        .pend_bits(pend_bits), .ctrl_bits(ctrl_bits)
    );

    function automatic logic exp_enum();
        return (m_ins | m_ext) & ~m_mask;
    endfunction

    function automatic logic exp_led();
        return m_sess ? m_led : 1'b1;
    endfunction

    task automatic model_edge();
        logic s, ni, ne;
        s = power_good & ~host_sel_n;
        if (!rst_n) begin
            m_ins = 0; m_ext = 0; m_led = 0; m_mask = 0; m_sess = 0;
        end else begin
            m_sess = s;
            if (!s) begin
                m_ins = 0; m_ext = 0; m_led = 0; m_mask = 0;
            end else begin
                ni = m_ins; ne = m_ext;
                if (wr_en && wr_addr == 1'b0) begin
                    if (wr_data[0]) ni = 0;
                    if (wr_data[1]) ne = 0;
                end
                if (wr_en && wr_addr == 1'b1) begin
                    m_led = wr_data[0]; m_mask = wr_data[1];
                end
                if (handle_closed && !m_hprev) ni = 1;
                if (!handle_closed && m_hprev) ne = 1;
                m_ins = ni; m_ext = ne;
            end
        end
        m_hprev = handle_closed;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: model updates at the edge, outputs compared at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "enum_pull", enum_pull, exp_enum());
        chk(tag, "led_on",    led_on,    exp_led());
        chk(tag, "pend_bits", pend_bits, {m_ext, m_ins});
        chk(tag, "ctrl_bits", ctrl_bits, {m_mask, m_led});
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1'b1;
        step("R1");
        chk("R1", "led reset", led_on, 1);
        chk("R1", "enum reset", enum_pull, 0);

        // Handle movement before a session: nothing latched (R6)
        handle_closed = 1; step("R6");
        handle_closed = 0; step("R6");
        chk("R6", "pend outside", pend_bits, 0);
        // Write outside session ignored (R10)
        wr(1'b1, 2'b11); step("R10");
        chk("R10", "ctrl after write", ctrl_bits, 0);

        // Start session: LED goes dark (R3)
        power_good = 1; step("R2");
        chk("R2", "led only powered", led_on, 1);
        host_sel_n = 0; step("R3");
        chk("R3", "led dark", led_on, 0);

        // Insertion (R4), ENUM (R8)
        handle_closed = 1; step("R4");
        chk("R4", "ins pending", pend_bits, 2'b01);
        chk("R8", "enum on", enum_pull, 1);

        // Mask keeps status (R8, R11)
        wr(1'b1, 2'b10); step("R11");
        chk("R8", "masked enum", enum_pull, 0);
        chk("R8", "status kept", pend_bits, 2'b01);
        wr(1'b1, 2'b01); step("R11");
        chk("R8", "unmasked enum", enum_pull, 1);
        chk("R3", "sw led", led_on, 1);

        // W1C: zero leaves, one clears (R7)
        wr(1'b0, 2'b10); step("R7");
        chk("R7", "zero write keeps", pend_bits, 2'b01);
        wr(1'b0, 2'b01); step("R7");
        chk("R7", "w1c clears", pend_bits, 2'b00);
        chk("R8", "enum released", enum_pull, 0);

        // Extraction with a simultaneous clear: event wins (R5, R7)
        handle_closed = 0; wr(1'b0, 2'b11); step("R5");
        chk("R5", "ext pending", pend_bits, 2'b10);
        chk("R7", "event beats clear", enum_pull, 1);

        // Session loss clears everything (R9)
        host_sel_n = 1; step("R9");
        chk("R9", "pend cleared", pend_bits, 0);
        chk("R9", "led hw on", led_on, 1);
        chk("R9", "enum off", enum_pull, 0);

        // Session resumes with handle already closed: no insertion (R6)
        handle_closed = 1; step("R6");
        host_sel_n = 0; step("R6");
        chk("R6", "closed at start", pend_bits, 0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) power_good = ~power_good;
            else if (r < 6) host_sel_n = ~host_sel_n;
            if ($urandom_range(0, 9) < 2) handle_closed = ~handle_closed;
            if ($urandom_range(0, 9) < 3) wr(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            if (r > 60 && r < 64) begin power_good = 1; host_sel_n = 0; end
            step("R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule